// File: doc/BRIEF.md
# Aligned Divider Change Controller

This block drives a bank of clock dividers from one input clock. Software never changes a running divider directly. It writes new ratios into shadow registers, selects through a mask which dividers restart in phase, and then issues a GO command. The block snapshots the shadow values on GO and raises a busy flag for a fixed number of input cycles. On the final cycle of that window, every selected divider restarts on the same edge with its new setting. A divider left out of the mask keeps its phase and switches over at its next natural wrap.

Each divider output is a one-cycle-wide tick: a clock enable that is high once per divided period. A global mode register can put the whole bank in bypass. In bypass every output is high on every cycle, so the input rate passes through undivided. Registers are reached through a single-cycle write strobe with an address, and a combinational read of the addressed register.

Top module: `align_div_ctrl`

## Requirements
- R1: After reset, STAT (address 2) reads 0, MODE (address 0) and both divider registers (addresses 4 and 5) read 0, and the bank is in bypass.
- R2: When MODE bit 0 (enable) and MODE bit 5 (source select) are both 0, every div_tick bit is 1 on every cycle whatever the divider settings. If either bit is 1, the dividers drive the outputs.
- R3: A divider register at address 4+k holds an enable in bit 15 and a ratio value r in bits 6:0. Once active and enabled, divider k ticks exactly once every r+1 input cycles (r=0 means divide-by-1). A disabled divider never ticks outside bypass.
- R4: A write of 1 to CMD (address 1) bit 0, while that bit holds 0 and busy is 0, starts a change. STAT bit 0 then reads 1 for exactly 4 cycles and returns to 0.
- R5: Any CMD write while busy is 1 is ignored. It does not restart or lengthen the change, and the CMD bit keeps its value.
- R6: Divider-register writes made while busy is 1 update only the shadow copy, which reads back at once. The change in progress applies the values captured at GO, and the new shadow values take effect only at a later GO.
- R7: Dividers whose bit is set in ALIGN (address 3, bit k for divider k) restart together. Each enabled one ticks in the first cycle busy reads 0, and then ticks at its new ratio.
- R8: A divider whose ALIGN bit was 0 at GO keeps its old phase and period until its next terminal count after GO. From that wrap onward it ticks at its new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, divided by the bank |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Contents of the addressed register (combinational) |
| div_tick | output | 2 | One tick per divided period for each divider; all high in bypass |

## Verification
Register writes can land in the same cycles as a change in progress. The bench forces this overlap by writing a new shadow ratio, clearing CMD and writing GO again within the first three busy cycles. It then judges the result in three ways: the busy window must still be exactly four cycles long, the shadow must read back the new value, and the divider must keep ticking at the ratio captured at GO. A second overlap comes from an unaligned divider whose terminal count falls inside the busy window. Its tick positions are compared cycle by cycle against a model in which that divider keeps its old phase up to that wrap, while the aligned divider restarts on the completion edge.

// File: rtl/align_div_pkg.sv
package align_div_pkg;
  // register addresses
  localparam int ADR_MODE     = 0;
  localparam int ADR_CMD      = 1;
  localparam int ADR_STAT     = 2;
  localparam int ADR_ALIGN    = 3;
  localparam int ADR_DIV_BASE = 4;

  // bit positions inside registers
  localparam int MODE_EN_BIT   = 0;
  localparam int MODE_SRC_BIT  = 5;
  localparam int CMD_GO_BIT    = 0;
  localparam int STAT_BUSY_BIT = 0;
endpackage

// File: rtl/adiv_regfile.sv
module adiv_regfile
  import align_div_pkg::*;
#(
  parameter int NUM_DIV = 2,
  parameter int RATIO_W = 7,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int EN_BIT  = 15
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic                              busy,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              go_start,
  output logic                              bypass,
  output logic [NUM_DIV-1:0]                align_q,
  output logic [NUM_DIV-1:0]                sh_en_q,
  output logic [NUM_DIV-1:0][RATIO_W-1:0]   sh_ratio_q
);

  logic                            mode_en_q, mode_en_d;
  logic                            mode_src_q, mode_src_d;
  logic                            go_q, go_d;
  logic [NUM_DIV-1:0]              align_d;
  logic [NUM_DIV-1:0]              sh_en_d;
  logic [NUM_DIV-1:0][RATIO_W-1:0] sh_ratio_d;

  logic wr_mode, wr_cmd, wr_align;

  assign wr_mode  = wr_en && (addr == ADDR_W'(ADR_MODE));
  assign wr_cmd   = wr_en && (addr == ADDR_W'(ADR_CMD));
  assign wr_align = wr_en && (addr == ADDR_W'(ADR_ALIGN));

  // a change starts only on a 0->1 transition of the command bit while idle
  assign go_start = wr_cmd && !busy && wdata[CMD_GO_BIT] && !go_q;
  assign bypass   = !mode_en_q && !mode_src_q;

  always_comb begin
    mode_en_d  = mode_en_q;
    mode_src_d = mode_src_q;
    go_d       = go_q;
    align_d    = align_q;
    sh_en_d    = sh_en_q;
    sh_ratio_d = sh_ratio_q;
    if (wr_mode) begin
      mode_en_d  = wdata[MODE_EN_BIT];
      mode_src_d = wdata[MODE_SRC_BIT];
    end
    if (wr_cmd && !busy) begin
      go_d = wdata[CMD_GO_BIT];
    end
    if (wr_align) begin
      align_d = wdata[NUM_DIV-1:0];
    end
    for (int k = 0; k < NUM_DIV; k++) begin
      if (wr_en && (addr == ADDR_W'(ADR_DIV_BASE + k))) begin
        sh_en_d[k]    = wdata[EN_BIT];
        sh_ratio_d[k] = wdata[RATIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en_q  <= 1'b0;
      mode_src_q <= 1'b0;
      go_q       <= 1'b0;
      align_q    <= '0;
      sh_en_q    <= '0;
      sh_ratio_q <= '0;
    end else begin
      mode_en_q  <= mode_en_d;
      mode_src_q <= mode_src_d;
      go_q       <= go_d;
      align_q    <= align_d;
      sh_en_q    <= sh_en_d;
      sh_ratio_q <= sh_ratio_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADR_MODE)) begin
      rdata[MODE_EN_BIT]  = mode_en_q;
      rdata[MODE_SRC_BIT] = mode_src_q;
    end else if (addr == ADDR_W'(ADR_CMD)) begin
      rdata[CMD_GO_BIT] = go_q;
    end else if (addr == ADDR_W'(ADR_STAT)) begin
      rdata[STAT_BUSY_BIT] = busy;
    end else if (addr == ADDR_W'(ADR_ALIGN)) begin
      rdata[NUM_DIV-1:0] = align_q;
    end
    for (int k = 0; k < NUM_DIV; k++) begin
      if (addr == ADDR_W'(ADR_DIV_BASE + k)) begin
        rdata[EN_BIT]        = sh_en_q[k];
        rdata[RATIO_W-1:0]   = sh_ratio_q[k];
      end
    end
  end

endmodule

// File: rtl/adiv_sequencer.sv
module adiv_sequencer #(
  parameter int NUM_DIV    = 2,
  parameter int RATIO_W    = 7,
  parameter int CHG_CYCLES = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              go_start,
  input  logic [NUM_DIV-1:0]                align_in,
  input  logic [NUM_DIV-1:0]                en_in,
  input  logic [NUM_DIV-1:0][RATIO_W-1:0]   ratio_in,
  output logic                              busy,
  output logic                              done,
  output logic [NUM_DIV-1:0]                snap_align,
  output logic [NUM_DIV-1:0]                snap_en,
  output logic [NUM_DIV-1:0][RATIO_W-1:0]   snap_ratio
);

  localparam int CNT_W = $clog2(CHG_CYCLES + 1);

  logic                            busy_d;
  logic [CNT_W-1:0]                cnt_q, cnt_d;
  logic [NUM_DIV-1:0]              snap_align_d, snap_en_d;
  logic [NUM_DIV-1:0][RATIO_W-1:0] snap_ratio_d;

  assign done = busy && (cnt_q == CNT_W'(CHG_CYCLES - 1));

  always_comb begin
    busy_d       = busy;
    cnt_d        = cnt_q;
    snap_align_d = snap_align;
    snap_en_d    = snap_en;
    snap_ratio_d = snap_ratio;
    if (go_start) begin
      busy_d       = 1'b1;
      cnt_d        = '0;
      snap_align_d = align_in;
      snap_en_d    = en_in;
      snap_ratio_d = ratio_in;
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt_q      <= '0;
      snap_align <= '0;
      snap_en    <= '0;
      snap_ratio <= '0;
    end else begin
      busy       <= busy_d;
      cnt_q      <= cnt_d;
      snap_align <= snap_align_d;
      snap_en    <= snap_en_d;
      snap_ratio <= snap_ratio_d;
    end
  end

endmodule

// File: rtl/adiv_channel.sv
module adiv_channel #(
  parameter int RATIO_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bypass,
  input  logic               cap,
  input  logic               done,
  input  logic               aligned,
  input  logic               new_en,
  input  logic [RATIO_W-1:0] new_ratio,
  output logic               tick,
  output logic               act_en
);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic               en_d;
  logic               pend_q, pend_d;
  logic               term;
  logic               apply;

  assign term  = act_en && (cnt_q == ratio_q);
  // aligned: apply on completion; unaligned: at next wrap, or on completion if idle
  assign apply = pend_q && (aligned ? done : (act_en ? term : done));
  assign tick  = bypass || (act_en && (cnt_q == '0));

  always_comb begin
    en_d    = act_en;
    ratio_d = ratio_q;
    pend_d  = pend_q;
    if (act_en) begin
      cnt_d = term ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
    if (cap) begin
      pend_d = 1'b1;
    end else if (apply) begin
      en_d    = new_en;
      ratio_d = new_ratio;
      cnt_d   = '0;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en  <= 1'b0;
      ratio_q <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      act_en  <= en_d;
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

endmodule

// File: rtl/align_div_ctrl.sv
module align_div_ctrl #(
  parameter int NUM_DIV    = 2,
  parameter int RATIO_W    = 7,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 3,
  parameter int EN_BIT     = 15,
  parameter int CHG_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_DIV-1:0] div_tick
);

  logic [1:0]                      rst_pipe;
  logic                            rst_sync_n;
  logic                            go_start;
  logic                            bypass;
  logic                            busy;
  logic                            done;
  logic [NUM_DIV-1:0]              align_q;
  logic [NUM_DIV-1:0]              sh_en;
  logic [NUM_DIV-1:0][RATIO_W-1:0] sh_ratio;
  logic [NUM_DIV-1:0]              snap_align;
  logic [NUM_DIV-1:0]              snap_en;
  logic [NUM_DIV-1:0][RATIO_W-1:0] snap_ratio;
  logic [NUM_DIV-1:0]              act_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  adiv_regfile #(
    .NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .EN_BIT(EN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy), .rdata(rdata), .go_start(go_start), .bypass(bypass),
    .align_q(align_q), .sh_en_q(sh_en), .sh_ratio_q(sh_ratio)
  );

  adiv_sequencer #(
    .NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W), .CHG_CYCLES(CHG_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .go_start(go_start), .align_in(align_q),
    .en_in(sh_en), .ratio_in(sh_ratio), .busy(busy), .done(done),
    .snap_align(snap_align), .snap_en(snap_en), .snap_ratio(snap_ratio)
  );

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_ch
    adiv_channel #(.RATIO_W(RATIO_W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .bypass(bypass), .cap(go_start),
      .done(done), .aligned(snap_align[k]), .new_en(snap_en[k]),
      .new_ratio(snap_ratio[k]), .tick(div_tick[k]), .act_en(act_en[k])
    );
  end

endmodule

// File: rtl/adiv_checker.sv
module adiv_checker #(
  parameter int NUM_DIV    = 2,
  parameter int RATIO_W    = 7,
  parameter int CHG_CYCLES = 4
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              busy,
  input logic                              bypass,
  input logic [NUM_DIV-1:0]                div_tick,
  input logic [NUM_DIV-1:0]                act_en,
  input logic [NUM_DIV-1:0]                snap_align,
  input logic [NUM_DIV-1:0]                snap_en,
  input logic [NUM_DIV-1:0][RATIO_W-1:0]   snap_ratio
);

  localparam int RUN_W = $clog2(CHG_CYCLES + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (busy) begin
      if (run_q != RUN_W'(CHG_CYCLES + 1)) run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  AST_BUSY_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RUN_W'(CHG_CYCLES))); // R5

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RUN_W'(CHG_CYCLES))); // R4

  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(snap_en) && $stable(snap_ratio) && $stable(snap_align))); // R6

  AST_ALIGNED_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !bypass) |-> ((div_tick & snap_align & act_en) == (snap_align & act_en))); // R7

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (&div_tick)); // R2

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> ((div_tick & ~act_en) == '0)); // R3

endmodule

bind align_div_ctrl adiv_checker #(
  .NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W), .CHG_CYCLES(CHG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy), .bypass(bypass),
  .div_tick(div_tick), .act_en(act_en), .snap_align(snap_align),
  .snap_en(snap_en), .snap_ratio(snap_ratio)
);

// File: tb/sim_align_div_ctrl.sv
`timescale 1ns/1ps
module sim_align_div_ctrl;

  localparam int A_MODE = 0, A_CMD = 1, A_STAT = 2, A_ALIGN = 3, A_DIV0 = 4, A_DIV1 = 5;
  localparam int NVEC = 5;
  localparam int WIN  = 24;
  // {div0 reg, div1 reg, expected div0 ticks in WIN, expected div1 ticks in WIN}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'h8000, 16'h8001, 16'd24, 16'd12},
    {16'h8002, 16'h8003, 16'd8,  16'd6},
    {16'h8004, 16'h0002, 16'd5,  16'd0},
    {16'h8007, 16'h8005, 16'd3,  16'd4},
    {16'h0000, 16'h8000, 16'd0,  16'd24}
  };

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  div_tick;

  int n_chk;
  int n_bad;
  int bcnt;
  int t0, t1;
  logic [1:0] first;
  logic [15:0] rv;
  int mis0, mis1;
  bit e0, e1;

  align_div_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .div_tick(div_tick)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [15:0] d);
    wr_en = 1'b1;
    addr  = 3'(a);
    wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
    addr  = 3'(A_STAT);
  endtask

  task automatic rd_reg(input int a, output logic [15:0] d);
    addr = 3'(a);
    #1;
    d = rdata;
    addr = 3'(A_STAT);
    #1;
  endtask

  // issue GO, return busy length; ends at the first sample where busy is 0
  task automatic go_wait(output int n);
    wr_reg(A_CMD, 16'h0000);
    wr_reg(A_CMD, 16'h0001);
    n = 0;
    while (rdata[0] && n < 100) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic count_ticks(output int c0, output int c1, output logic [1:0] f);
    c0 = 0; c1 = 0;
    f = div_tick;
    for (int i = 0; i < WIN; i++) begin
      c0 += int'(div_tick[0]);
      c1 += int'(div_tick[1]);
      @(negedge clk); #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R4 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = 3'(A_STAT); wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;

    // R1 reset state
    rd_reg(A_STAT, rv); check("R1 stat", int'(rv), 0);
    rd_reg(A_MODE, rv); check("R1 mode", int'(rv), 0);
    rd_reg(A_DIV0, rv); check("R1 div0", int'(rv), 0);
    rd_reg(A_DIV1, rv); check("R1 div1", int'(rv), 0);
    check("R1 bypass ticks", int'(div_tick), 3);

    // R2 / R3 mode selection with disabled dividers
    wr_reg(A_MODE, 16'h0001);
    check("R3 disabled no tick", int'(div_tick), 0);
    wr_reg(A_MODE, 16'h0020);
    check("R2 src bit leaves bypass", int'(div_tick), 0);
    wr_reg(A_MODE, 16'h0000);
    check("R2 bypass", int'(div_tick), 3);
    wr_reg(A_MODE, 16'h0001);

    // vector table: aligned changes of both dividers (R3, R4, R7)
    for (int v = 0; v < NVEC; v++) begin
      wr_reg(A_DIV0, VEC[v][63:48]);
      wr_reg(A_DIV1, VEC[v][47:32]);
      wr_reg(A_ALIGN, 16'h0003);
      go_wait(bcnt);
      check("R4 busy length", bcnt, 4);
      count_ticks(t0, t1, first);
      check("R3 div0 ticks", t0, int'(VEC[v][31:16]));
      check("R3 div1 ticks", t1, int'(VEC[v][15:0]));
      check("R7 first-cycle ticks", int'(first),
            int'({VEC[v][15:0] != 0, VEC[v][31:16] != 0}));
    end

    // R5 / R6: writes during busy
    wr_reg(A_DIV0, 16'h8001);
    wr_reg(A_DIV1, 16'h8001);
    wr_reg(A_ALIGN, 16'h0003);
    wr_reg(A_CMD, 16'h0000);
    wr_reg(A_CMD, 16'h0001);
    bcnt = 0;
    for (int i = 0; i < 10; i++) begin
      wr_en = 1'b0; addr = 3'(A_STAT);
      #1;
      bcnt += int'(rdata[0]);
      if (i == 0) begin wr_en = 1'b1; addr = 3'(A_DIV0); wdata = 16'h8005; end
      if (i == 1) begin wr_en = 1'b1; addr = 3'(A_CMD);  wdata = 16'h0000; end
      if (i == 2) begin wr_en = 1'b1; addr = 3'(A_CMD);  wdata = 16'h0001; end
      @(negedge clk); #1;
    end
    wr_en = 1'b0; addr = 3'(A_STAT);
    check("R5 busy not extended", bcnt, 4);
    rd_reg(A_CMD, rv); check("R5 cmd bit kept", int'(rv), 1);
    rd_reg(A_DIV0, rv); check("R6 shadow readback", int'(rv), 32'h8005);
    count_ticks(t0, t1, first);
    check("R6 active keeps captured ratio", t0, 12);
    go_wait(bcnt);
    count_ticks(t0, t1, first);
    check("R6 shadow applied on next GO", t0, 4);

    // R7 / R8: one aligned, one unaligned divider
    wr_reg(A_DIV0, 16'h8003);
    wr_reg(A_DIV1, 16'h8003);
    wr_reg(A_ALIGN, 16'h0003);
    go_wait(bcnt);
    mis0 = 0; mis1 = 0;
    for (int s = 0; s < 40; s++) begin
      wr_en = 1'b0; addr = 3'(A_STAT);
      #1;
      e0 = (s < 10) ? (s % 4 == 0) : ((s - 10) % 3 == 0);
      e1 = (s <= 8) ? (s % 4 == 0) : (s % 2 == 0);
      if (div_tick[0] != e0) mis0++;
      if (div_tick[1] != e1) mis1++;
      if (s == 1) begin wr_en = 1'b1; addr = 3'(A_DIV1);  wdata = 16'h8001; end
      if (s == 2) begin wr_en = 1'b1; addr = 3'(A_DIV0);  wdata = 16'h8002; end
      if (s == 3) begin wr_en = 1'b1; addr = 3'(A_ALIGN); wdata = 16'h0001; end
      if (s == 4) begin wr_en = 1'b1; addr = 3'(A_CMD);   wdata = 16'h0000; end
      if (s == 5) begin wr_en = 1'b1; addr = 3'(A_CMD);   wdata = 16'h0001; end
      @(negedge clk); #1;
    end
    wr_en = 1'b0; addr = 3'(A_STAT);
    check("R7 aligned restart pattern mismatches", mis0, 0);
    check("R8 unaligned phase kept mismatches", mis1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule